// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns a parallel payload word into a serial frame on one output line. The frame carries its own timing reference. The environment supplies a single bit-rate clock and pulses a word strobe once every frame period, which is twelve clocks with the default ten-bit payload. On an accepted strobe the block captures the word into its shift register. In the following clocks it sends a frame that opens with a high marker bit, carries the payload least-significant bit first, and closes with a low marker bit. The fixed high-to-low pair guarantees at least one edge per frame, and a receiver recovers its clock from that edge.

A receiver that has lost alignment can be helped back by a synchronization burst. Two request inputs are ORed and sampled on each strobe. A request counts only once it has been seen on enough consecutive strobes. After that, each frame is a half-high, half-low pattern and the payload input is ignored. A burst always runs to a minimum number of frames, and it keeps going for as long as a request stays high. A line enable takes the driver off the line without disturbing the frame sequence. Dropping the power input clears the lock and the burst state. When power returns, the block counts a fixed number of strobes as a lock wait before it sends any frame, and a ready output shows when that wait has ended.

Top module: `frame_serializer`

## Requirements
- R1: A frame has PAYLOAD_W+2 slots, with slot 0 in the clock after the accepted strobe. Slot 0 is 1 (start), slot i+1 carries din[i] for i = 0..PAYLOAD_W-1, and the last slot is 0 (stop).
- R2: The payload is captured at the strobe edge. Changes to din after that edge do not alter the frame being sent.
- R3: A synchronization frame drives its first half of slots high and its second half low (12'h03F, bit i = slot i, in the default configuration).
- R4: The two request inputs are ORed, so either one keeps a burst going. The payload input has no effect on any frame sent as a synchronization frame.
- R5: A request seen on fewer than SYNC_HOLD (default 5) consecutive accepted strobes produces no synchronization frame.
- R6: A request qualifies on its SYNC_HOLD-th consecutive strobe, and that frame is the first synchronization frame. A request released right after qualifying yields exactly SYNC_MIN (default 1024) synchronization frames, followed by a data frame.
- R7: A request held past SYNC_MIN frames keeps synchronization frames going up to the last strobe at which it is high. The next strobe with both requests low sends a data frame.
- R8: While out_en is 0, ser_oe is 0 and the frame sequence carries on unchanged on ser_out. When out_en returns to 1, output resumes in the same state.
- R9: While pwr_on is 0, ser_oe and ready are 0 and ser_out stays 0. Any pending synchronization burst is cleared.
- R10: After reset or after pwr_on rises, the first LOCK_WAIT (default 2048) strobes send no frame, and ready goes to 1 in the clock after the LOCK_WAIT-th strobe. Strobe LOCK_WAIT+1 carries the first frame.
- R11: Once ready is 1, it stays 1 for as long as pwr_on stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | Word strobe, one pulse per frame period |
| din | input | PAYLOAD_W | Parallel payload word |
| sync_req_a | input | 1 | Synchronization request, first source |
| sync_req_b | input | 1 | Synchronization request, second source |
| out_en | input | 1 | Line enable; 0 floats the output |
| pwr_on | input | 1 | Run control; 0 powers the block down |
| ser_out | output | 1 | Serial frame bit |
| ser_oe | output | 1 | Line driver enable (0 means high impedance) |
| ready | output | 1 | Lock wait finished, frames are being sent |

## Verification
Data frames are sent with all-zero, all-one, alternating and single-bit payloads. The all-zero and all-one words separate a wrong payload from misplaced start and stop markers. The alternating and single-bit words expose bit-order and off-by-one slot errors, and din is inverted right after every strobe to show that the word was captured. Request patterns are a four-strobe pulse, a request held exactly to qualification, and a long request handed over between the two inputs. Counting the synchronization frames in each case separates a wrong hold threshold from a wrong minimum burst length and from a burst that ignores one of the inputs. The lock wait is measured strobe by strobe after reset and again after a powerdown taken in the middle of a burst, which also shows whether the burst state survives the powerdown.

// File: rtl/frame_ser_pkg.sv
package frame_ser_pkg;

   // Kind of frame launched on an accepted strobe
   typedef enum logic {
      FK_DATA = 1'b0,
      FK_SYNC = 1'b1
   } frame_kind_e;

   // Marker levels that bracket every data frame
   localparam logic START_LVL = 1'b1;
   localparam logic STOP_LVL  = 1'b0;

endpackage

// File: rtl/fs_lock_timer.sv
module fs_lock_timer #(
   parameter int unsigned LOCK_WAIT = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   input  logic word_stb,
   output logic locked
);
   localparam int unsigned CW = $clog2(LOCK_WAIT + 1);

   logic [CW-1:0] cnt_q;

   assign locked = (cnt_q == CW'(LOCK_WAIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!pwr_on)
         cnt_q <= '0;
      else if (word_stb && !locked)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/fs_sync_ctrl.sv
module fs_sync_ctrl
   import frame_ser_pkg::*;
#(
   parameter int unsigned SYNC_HOLD = 5,
   parameter int unsigned SYNC_MIN  = 1024
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        take,
   input  logic        req,
   output frame_kind_e kind
);
   localparam int unsigned RW = $clog2(SYNC_HOLD + 1);
   localparam int unsigned BW = $clog2(SYNC_MIN + 1);

   logic [RW-1:0] run_q;   // consecutive strobes with a request, saturating
   logic [BW-1:0] sent_q;  // synchronization frames in the current burst
   logic          qual;
   logic          burst_open;

   assign qual       = req && (run_q == RW'(SYNC_HOLD - 1));
   assign burst_open = (sent_q != '0) && (sent_q < BW'(SYNC_MIN));
   assign kind       = (qual || burst_open) ? FK_SYNC : FK_DATA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         sent_q <= '0;
      end else if (clr) begin
         run_q  <= '0;
         sent_q <= '0;
      end else if (take) begin
         if (!req)
            run_q <= '0;
         else if (run_q != RW'(SYNC_HOLD - 1))
            run_q <= run_q + 1'b1;

         if (kind == FK_DATA)
            sent_q <= '0;
         else if (sent_q != BW'(SYNC_MIN))
            sent_q <= sent_q + 1'b1;
      end
   end
endmodule

// File: rtl/fs_frame_shifter.sv
module fs_frame_shifter
   import frame_ser_pkg::*;
#(
   parameter int unsigned PAYLOAD_W = 10,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 take,
   input  frame_kind_e          kind,
   input  logic [PAYLOAD_W-1:0] din,
   output logic                 ser_bit
);
   localparam int unsigned FW = PAYLOAD_W + 2;

   logic [FW-1:0] data_frame;
   logic [FW-1:0] sync_frame;
   logic [FW-1:0] sh_q;

   assign data_frame[0]    = START_LVL;
   assign data_frame[FW-1] = STOP_LVL;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign data_frame[FW-2:1] = din;
      end else begin : g_msb_first
         for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_bit
            assign data_frame[1+i] = din[PAYLOAD_W-1-i];
         end
      end

      for (genvar j = 0; j < FW; j++) begin : g_sync
         assign sync_frame[j] = (j < FW / 2) ? 1'b1 : 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (clr)
         sh_q <= '0;
      else if (take)
         sh_q <= (kind == FK_SYNC) ? sync_frame : data_frame;
      else
         sh_q <= {1'b0, sh_q[FW-1:1]};
   end

   assign ser_bit = sh_q[0];
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
   import frame_ser_pkg::*;
#(
   parameter int unsigned PAYLOAD_W = 10,
   parameter int unsigned SYNC_HOLD = 5,
   parameter int unsigned SYNC_MIN  = 1024,
   parameter int unsigned LOCK_WAIT = 2048,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 word_stb,
   input  logic [PAYLOAD_W-1:0] din,
   input  logic                 sync_req_a,
   input  logic                 sync_req_b,
   input  logic                 out_en,
   input  logic                 pwr_on,
   output logic                 ser_out,
   output logic                 ser_oe,
   output logic                 ready
);
   localparam int unsigned FRAME_W = PAYLOAD_W + 2;

   generate
      if (PAYLOAD_W < 1) begin : g_bad_payload
         $error("PAYLOAD_W must be at least 1");
      end
      if ((FRAME_W % 2) != 0) begin : g_bad_half
         $error("PAYLOAD_W must be even so the sync pattern splits in halves");
      end
      if (SYNC_HOLD < 1 || SYNC_MIN < 1 || LOCK_WAIT < 1) begin : g_bad_count
         $error("SYNC_HOLD, SYNC_MIN and LOCK_WAIT must be at least 1");
      end
   endgenerate

   logic        locked;
   logic        take;
   logic        pdown;
   frame_kind_e kind;

   assign pdown = !pwr_on;
   assign ready = pwr_on && locked;
   assign take  = word_stb && ready;

   fs_lock_timer #(
      .LOCK_WAIT (LOCK_WAIT)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_on   (pwr_on),
      .word_stb (word_stb),
      .locked   (locked)
   );

   fs_sync_ctrl #(
      .SYNC_HOLD (SYNC_HOLD),
      .SYNC_MIN  (SYNC_MIN)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pdown),
      .take  (take),
      .req   (sync_req_a || sync_req_b),
      .kind  (kind)
   );

   fs_frame_shifter #(
      .PAYLOAD_W (PAYLOAD_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pdown),
      .take    (take),
      .kind    (kind),
      .din     (din),
      .ser_bit (ser_out)
   );

   assign ser_oe = out_en && ready;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
   parameter int unsigned FRAME_W   = 12,
   parameter int unsigned LOCK_WAIT = 2048
) (
   input logic clk,
   input logic rst_n,
   input logic word_stb,
   input logic out_en,
   input logic pwr_on,
   input logic ser_out,
   input logic ser_oe,
   input logic ready
);
   localparam int unsigned SW = $clog2(FRAME_W + 1);
   localparam int unsigned LW = $clog2(LOCK_WAIT + 1);

   logic [SW-1:0] slot_q;
   logic          armed_q;
   logic [LW-1:0] lk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= '0;
         armed_q <= 1'b0;
      end else if (word_stb && ready) begin
         slot_q  <= SW'(1);
         armed_q <= 1'b1;
      end else if (slot_q != SW'(FRAME_W)) begin
         slot_q  <= slot_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lk_q <= '0;
      else if (!pwr_on)
         lk_q <= '0;
      else if (word_stb && !ready)
         lk_q <= lk_q + 1'b1;
   end

   // R1
   start_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && ready) |=> ser_out);

   // R1
   stop_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && slot_q == SW'(FRAME_W)) |-> !ser_out);

   // R8
   line_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> !ser_oe);

   // R9
   lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> !ready);

   // R10
   lock_wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (lk_q == LW'(LOCK_WAIT)));

   // R11
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && pwr_on) ##1 pwr_on |-> ready);
endmodule

bind frame_serializer fs_checker #(
   .FRAME_W   (PAYLOAD_W + 2),
   .LOCK_WAIT (LOCK_WAIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .word_stb (word_stb),
   .out_en   (out_en),
   .pwr_on   (pwr_on),
   .ser_out  (ser_out),
   .ser_oe   (ser_oe),
   .ready    (ready)
);

// File: tb/sim_frame_serializer.sv
`timescale 1ns/1ps
module sim_frame_serializer;
   localparam logic [11:0] SYNC_EXP = 12'h03F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       word_stb = 1'b0;
   logic [9:0] din = '0;
   logic       sync_req_a = 1'b0;
   logic       sync_req_b = 1'b0;
   logic       out_en = 1'b1;
   logic       pwr_on = 1'b1;
   logic       ser_out, ser_oe, ready;

   int n_chk = 0;
   int n_err = 0;

   logic [11:0] fr_bits;
   logic        fr_oe, fr_rdy;

   always #10 clk = ~clk;

   frame_serializer u0 (
      .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .din(din),
      .sync_req_a(sync_req_a), .sync_req_b(sync_req_b),
      .out_en(out_en), .pwr_on(pwr_on),
      .ser_out(ser_out), .ser_oe(ser_oe), .ready(ready)
   );

   function automatic logic [11:0] exp_data(input logic [9:0] d);
      return {1'b0, d, 1'b1};
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // Strobe one word at the current falling edge and sample all 12 slots
   task automatic send_frame(input logic [9:0] d);
      word_stb = 1'b1;
      din = d;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (k == 0) begin
            word_stb = 1'b0;
            din = ~d;
            fr_oe = ser_oe;
            fr_rdy = ready;
         end
         fr_bits[k] = ser_out;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(ready == 1'b0, "R10 reset ready", 32'(ready), 0);
      chk(ser_oe == 1'b0, "R10 reset oe", 32'(ser_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_lock();
      for (int n = 1; n <= 2049; n++) begin
         send_frame(10'(n * 37));
         if (n == 1) begin
            chk(fr_bits == 12'h000, "R10 no frame during wait", 32'(fr_bits), 0);
            chk(fr_oe == 1'b0, "R10 oe during wait", 32'(fr_oe), 0);
         end
         if (n == 2047) chk(fr_rdy == 1'b0, "R10 ready early", 32'(fr_rdy), 0);
         if (n == 2048) chk(fr_rdy == 1'b1, "R10 ready on time", 32'(fr_rdy), 1);
         if (n == 2049)
            chk(fr_bits == exp_data(10'(n * 37)), "R10 first frame", 32'(fr_bits),
                32'(exp_data(10'(n * 37))));
      end
   endtask

   task automatic t_data();
      logic [9:0] pats [6] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h001, 10'h200};
      for (int i = 0; i < 6; i++) begin
         send_frame(pats[i]);
         chk(fr_bits == exp_data(pats[i]), "R1/R2 data frame", 32'(fr_bits), 32'(exp_data(pats[i])));
      end
      chk(fr_oe == 1'b1, "R8 oe enabled", 32'(fr_oe), 1);
      chk(fr_rdy == 1'b1, "R11 ready held", 32'(fr_rdy), 1);
   endtask

   task automatic t_short_pulse();
      int bad = 0;
      sync_req_a = 1'b1;
      for (int f = 1; f <= 5; f++) begin
         if (f == 5) sync_req_a = 1'b0;
         send_frame(10'(f + 100));
         if (fr_bits != exp_data(10'(f + 100))) bad++;
      end
      chk(bad == 0, "R5 short pulse ignored", 32'(bad), 0);
   endtask

   task automatic t_sync_short();
      int bad = 0;
      int nsync = 0;
      logic [11:0] f5 = '0, f1029 = '0;
      for (int f = 1; f <= 1030; f++) begin
         sync_req_b = (f <= 5);
         send_frame(10'(f * 13));
         if (fr_bits == SYNC_EXP) nsync++;
         if (f == 5) f5 = fr_bits;
         if (f == 1029) f1029 = fr_bits;
         if (fr_bits != ((f >= 5 && f <= 1028) ? SYNC_EXP : exp_data(10'(f * 13)))) bad++;
      end
      sync_req_b = 1'b0;
      chk(f5 == SYNC_EXP, "R3 sync pattern", 32'(f5), 32'(SYNC_EXP));
      chk(nsync == 1024, "R6 burst length", 32'(nsync), 1024);
      chk(f1029 == exp_data(10'(1029 * 13)), "R6 data after burst", 32'(f1029),
          32'(exp_data(10'(1029 * 13))));
      chk(bad == 0, "R6 frame sequence", 32'(bad), 0);
   endtask

   task automatic t_sync_long();
      int bad = 0;
      int nsync = 0;
      logic [11:0] f900 = '0, f1501 = '0;
      for (int f = 1; f <= 1502; f++) begin
         sync_req_a = (f <= 800);
         sync_req_b = (f >= 700 && f <= 1500);
         send_frame(10'(f * 7));
         if (fr_bits == SYNC_EXP) nsync++;
         if (f == 900) f900 = fr_bits;
         if (f == 1501) f1501 = fr_bits;
         if (fr_bits != ((f >= 5 && f <= 1500) ? SYNC_EXP : exp_data(10'(f * 7)))) bad++;
      end
      sync_req_a = 1'b0;
      sync_req_b = 1'b0;
      chk(f900 == SYNC_EXP, "R4 second input alone", 32'(f900), 32'(SYNC_EXP));
      chk(nsync == 1496, "R7 long burst length", 32'(nsync), 1496);
      chk(f1501 == exp_data(10'(1501 * 7)), "R7 data after release", 32'(f1501),
          32'(exp_data(10'(1501 * 7))));
      chk(bad == 0, "R4 data ignored in burst", 32'(bad), 0);
   endtask

   task automatic t_oe();
      for (int f = 1; f <= 6; f++) begin
         out_en = !(f == 3 || f == 4);
         send_frame(10'(f * 91));
         if (f == 3) begin
            chk(fr_oe == 1'b0, "R8 line floated", 32'(fr_oe), 0);
            chk(fr_bits == exp_data(10'(f * 91)), "R8 sequence kept", 32'(fr_bits),
                32'(exp_data(10'(f * 91))));
         end
         if (f == 5) begin
            chk(fr_oe == 1'b1, "R8 line restored", 32'(fr_oe), 1);
            chk(fr_bits == exp_data(10'(f * 91)), "R8 resume data", 32'(fr_bits),
                32'(exp_data(10'(f * 91))));
         end
      end
      out_en = 1'b1;
   endtask

   task automatic t_pdown();
      sync_req_a = 1'b1;
      for (int f = 1; f <= 7; f++) send_frame(10'(f));
      chk(fr_bits == SYNC_EXP, "R6 burst before powerdown", 32'(fr_bits), 32'(SYNC_EXP));
      sync_req_a = 1'b0;
      pwr_on = 1'b0;
      for (int f = 1; f <= 3; f++) send_frame(10'h3FF);
      chk(fr_oe == 1'b0, "R9 oe off", 32'(fr_oe), 0);
      chk(fr_rdy == 1'b0, "R9 ready off", 32'(fr_rdy), 0);
      chk(fr_bits == 12'h000, "R9 line quiet", 32'(fr_bits), 0);
      pwr_on = 1'b1;
      t_lock();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_lock();
      t_data();
      t_short_pulse();
      t_sync_short();
      t_sync_long();
      t_oe();
      t_pdown();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule